// File: doc/BRIEF.md
# Staged 32-bit Barrel Shifter

This block is a purely combinational shifter for a 32-bit processor datapath. It takes a 32-bit operand and moves it by a 5-bit distance in one of four ways: logical left, logical right, arithmetic right or rotate right. A separate select picks a one-place rotate that passes through the carry flag. Besides the shifted value, it always returns a carry-out flag, and it does so for plain rotates too.

The shift runs through a cascade of five conditional stages that move the word by 16, 8, 4, 2 and 1 positions. Each bit of the distance enables one stage. The carry travels down the same cascade. An enabled stage replaces the carry with the last bit its own move pushed out. A disabled stage hands the carry on unchanged. The chain starts from the incoming carry flag, so a zero distance returns the operand and the incoming carry untouched.

Top module: `barrel_shifter32`

## Requirements
- R1: With the extended-rotate select low and a distance of zero, the result equals the operand and carry-out equals carry-in, for every shift kind.
- R2: Shift kind 2'b00 (logical left) by n in 1..31 gives operand << n with zeros in the low n bits, and carry-out is operand bit 32-n.
- R3: Shift kind 2'b01 (logical right) by n in 1..31 gives operand >> n with zeros in the top n bits, and carry-out is operand bit n-1.
- R4: Shift kind 2'b10 (arithmetic right) by n in 1..31 fills the top n bits with operand bit 31, and carry-out is operand bit n-1.
- R5: Shift kind 2'b11 (rotate right) by n in 1..31 moves operand bit (i+n) mod 32 into result bit i, and carry-out equals result bit 31.
- R6: With the extended-rotate select high, the result is {carry-in, operand[31:1]} and carry-out is operand bit 0, whatever the shift kind and distance.
- R7: Carry-in has no effect on the result unless the extended-rotate select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| rrx_i | input | 1 | Selects the one-place rotate through carry; overrides kind and distance |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
Whenever the inputs change, the assertions check the following properties of the result and carry:
- the pass-through at zero distance;
- the extended rotate;
- the rotate carry matching the top result bit;
- the zero or sign fill of the vacated positions for each linear shift.

Only the bench's sweeps show that every bit lands in the right place. They cover every kind against every distance from 0 to 31 over fixed and random operands. Checking that carry-in has no effect needs paired runs that differ only in that flag, which the bench also supplies.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    localparam int SH_WIDTH  = 32;
    localparam int SH_AMT_W  = $clog2(SH_WIDTH);
    localparam int SH_STAGES = SH_AMT_W;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef logic [SH_WIDTH-1:0] word_t;

    // Value and carry travelling together down the stage cascade.
    typedef struct packed {
        word_t data;
        logic  carry;
    } stage_bus_t;

    // Distance moved by stage index s (largest first).
    function automatic int stage_dist(input int s);
        return 1 << (SH_STAGES - 1 - s);
    endfunction

endpackage

// File: rtl/shift_stage.sv
module shift_stage
    import barrel_pkg::*;
#(
    parameter int DIST = 1
) (
    input  stage_bus_t  bus_in,
    input  shift_kind_e kind,
    input  logic        enable,
    input  logic        sign_bit,
    output stage_bus_t  bus_out
);
    localparam int W = SH_WIDTH;

    word_t moved;
    logic  lost_bit;

    always_comb begin
        unique case (kind)
            SK_LSL: begin
                moved    = {bus_in.data[W-DIST-1:0], {DIST{1'b0}}};
                lost_bit = bus_in.data[W-DIST];
            end
            SK_LSR: begin
                moved    = {{DIST{1'b0}}, bus_in.data[W-1:DIST]};
                lost_bit = bus_in.data[DIST-1];
            end
            SK_ASR: begin
                moved    = {{DIST{sign_bit}}, bus_in.data[W-1:DIST]};
                lost_bit = bus_in.data[DIST-1];
            end
            default: begin
                moved    = {bus_in.data[DIST-1:0], bus_in.data[W-1:DIST]};
                lost_bit = bus_in.data[DIST-1];
            end
        endcase
    end

    always_comb begin
        if (enable) begin
            bus_out.data  = moved;
            bus_out.carry = lost_bit;
        end else begin
            bus_out = bus_in;
        end
    end

endmodule

// File: rtl/rrx_unit.sv
module rrx_unit
    import barrel_pkg::*;
(
    input  word_t      operand,
    input  logic       carry_in,
    input  logic       select,
    input  stage_bus_t cascade,
    output stage_bus_t chosen
);
    stage_bus_t ext;

    always_comb begin
        ext.data  = {carry_in, operand[SH_WIDTH-1:1]};
        ext.carry = operand[0];
        chosen    = select ? ext : cascade;
    end

endmodule

// File: rtl/barrel_shifter32.sv
module barrel_shifter32
    import barrel_pkg::*;
(
    input  logic [31:0] operand_i,
    input  logic [1:0]  kind_i,
    input  logic [4:0]  amount_i,
    input  logic        rrx_i,
    input  logic        carry_i,
    output logic [31:0] result_o,
    output logic        carry_o
);
    stage_bus_t  chain [0:SH_STAGES];
    stage_bus_t  final_bus;
    shift_kind_e kind;

    assign kind     = shift_kind_e'(kind_i);
    assign chain[0] = '{data: operand_i, carry: carry_i};

    for (genvar s = 0; s < SH_STAGES; s++) begin : g_stage
        shift_stage #(.DIST(stage_dist(s))) u_stage (
            .bus_in   (chain[s]),
            .kind     (kind),
            .enable   (amount_i[SH_STAGES-1-s]),
            .sign_bit (operand_i[SH_WIDTH-1]),
            .bus_out  (chain[s+1])
        );
    end

    rrx_unit u_rrx (
        .operand  (operand_i),
        .carry_in (carry_i),
        .select   (rrx_i),
        .cascade  (chain[SH_STAGES]),
        .chosen   (final_bus)
    );

    assign result_o = final_bus.data;
    assign carry_o  = final_bus.carry;

endmodule

// File: rtl/barrel_shifter32_chk.sv
module barrel_shifter32_chk (
    input logic [31:0] operand_i,
    input logic [1:0]  kind_i,
    input logic [4:0]  amount_i,
    input logic        rrx_i,
    input logic        carry_i,
    input logic [31:0] result_o,
    input logic        carry_o
);
    logic [31:0] hi_mask;
    logic [31:0] lo_mask;

    always_comb begin
        hi_mask = ~(32'hFFFF_FFFF >> amount_i);
        lo_mask = ~(32'hFFFF_FFFF << amount_i);

        if (!rrx_i && amount_i == 5'd0) begin
            assert_zero_pass_R1: assert (result_o == operand_i && carry_o == carry_i);
        end
        if (!rrx_i && kind_i == 2'b00) begin
            assert_lsl_low_zero_R2: assert ((result_o & lo_mask) == 32'd0);
        end
        if (!rrx_i && kind_i == 2'b01) begin
            assert_lsr_high_zero_R3: assert ((result_o & hi_mask) == 32'd0);
        end
        if (!rrx_i && kind_i == 2'b10) begin
            assert_asr_sign_fill_R4: assert ((result_o & hi_mask) == (operand_i[31] ? hi_mask : 32'd0));
        end
        if (!rrx_i && kind_i == 2'b11 && amount_i != 5'd0) begin
            assert_ror_carry_R5: assert (carry_o == result_o[31]);
        end
        if (rrx_i) begin
            assert_rrx_R6: assert (result_o == {carry_i, operand_i[31:1]} && carry_o == operand_i[0]);
        end
    end

endmodule

bind barrel_shifter32 barrel_shifter32_chk u_chk (
    .operand_i (operand_i),
    .kind_i    (kind_i),
    .amount_i  (amount_i),
    .rrx_i     (rrx_i),
    .carry_i   (carry_i),
    .result_o  (result_o),
    .carry_o   (carry_o)
);

// File: tb/test_barrel_shifter32.sv
module test_barrel_shifter32;

    logic        clk = 1'b0;
    logic [31:0] operand_i = '0;
    logic [1:0]  kind_i = '0;
    logic [4:0]  amount_i = '0;
    logic        rrx_i = 1'b0;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic        carry_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    barrel_shifter32 i_barrel_shifter32 (
        .operand_i (operand_i),
        .kind_i    (kind_i),
        .amount_i  (amount_i),
        .rrx_i     (rrx_i),
        .carry_i   (carry_i),
        .result_o  (result_o),
        .carry_o   (carry_o)
    );

    function automatic logic [32:0] ref_model(input logic [31:0] op, input logic [1:0] k,
                                              input int n, input logic rrx, input logic cin);
        logic [31:0] r;
        logic        c;
        logic [63:0] dbl;
        if (rrx) return {{cin, op[31:1]}, op[0]};
        if (n == 0) return {op, cin};
        case (k)
            2'b00: begin r = op << n; c = op[32-n]; end
            2'b01: begin r = op >> n; c = op[n-1]; end
            2'b10: begin r = 32'($signed(op) >>> n); c = op[n-1]; end
            default: begin dbl = {op, op} >> n; r = dbl[31:0]; c = r[31]; end
        endcase
        return {r, c};
    endfunction

    task automatic apply(input logic [31:0] op, input logic [1:0] k, input int n,
                         input logic rrx, input logic cin, input string req);
        logic [32:0] exp;
        @(negedge clk);
        operand_i = op; kind_i = k; amount_i = 5'(n); rrx_i = rrx; carry_i = cin;
        #5;
        exp = ref_model(op, k, n, rrx, cin);
        checks++;
        if ({result_o, carry_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%h kind=%0d n=%0d rrx=%0b cin=%0b got %h/%0b exp %h/%0b",
                     req, op, k, n, rrx, cin, result_o, carry_o, exp[32:1], exp[0]);
        end
    endtask

    function automatic string req_of(input logic [1:0] k, input int n);
        if (n == 0) return "R1";
        case (k)
            2'b00: return "R2";
            2'b01: return "R3";
            2'b10: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        logic [31:0] pats [0:5];
        logic [32:0] ra, rb;
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0001;
        pats[3] = 32'h1234_5678; pats[4] = 32'hA5A5_5A5A; pats[5] = 32'h7FFF_FFFE;

        // Idle inputs: all-zero result and carry (R1 with zero operand)
        #5;
        checks++;
        if (result_o !== 32'd0 || carry_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle got %h/%0b exp 00000000/0", result_o, carry_o);
        end

        // Sweep every kind and distance, both carry values (R1..R5)
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 32; n++) begin
                for (int p = 0; p < 6; p++)
                    apply(pats[p], 2'(k), n, 1'b0, 1'(p & 1), req_of(2'(k), n));
                for (int r = 0; r < 4; r++)
                    apply($urandom, 2'(k), n, 1'b0, 1'($urandom), req_of(2'(k), n));
            end

        // Extended rotate ignores kind and distance (R6)
        for (int i = 0; i < 64; i++)
            apply((i < 6) ? pats[i] : $urandom, 2'(i), i % 32, 1'b1, 1'(i >> 1), "R6");

        // Carry-in has no effect on result outside extended rotate (R7)
        for (int i = 0; i < 128; i++) begin
            logic [31:0] op = $urandom;
            @(negedge clk);
            operand_i = op; kind_i = 2'(i); amount_i = 5'(i >> 2); rrx_i = 1'b0; carry_i = 1'b0;
            #5 ra = {result_o, carry_o};
            carry_i = 1'b1;
            #5 rb = {result_o, carry_o};
            checks++;
            if (ra[32:1] !== rb[32:1]) begin
                errors++;
                $display("FAIL R7 kind=%0d n=%0d got %h exp %h", i % 4, i >> 2, rb[32:1], ra[32:1]);
            end
        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule